// File: doc/BRIEF.md
# Keypad Speed Entry and Ramp Controller

This block turns a stream of decoded keypad presses into a signed speed setpoint for a variable-frequency drive, then moves the drive's working speed toward that setpoint slowly enough for a synchronous machine to follow. Digits build a decimal RPM entry of up to three digits. A minus key makes the entry negative, which reverses the direction of rotation. A commit key converts the entry to speed units, limits it, and loads it as the target.

The working speed is a signed value of a few bits. It moves by exactly one unit at a time, and only on update ticks supplied by the surrounding controller. The number of ticks between steps shrinks as the speed magnitude grows, so low speeds change gently and high speeds change faster. A reversal goes through zero one unit at a time. After each accepted key, a ready flag drops for a programmable hold time, and further keys are not taken until it returns.

Top module: `speed_entry_ramp`

## Requirements
- R1: A digit key (code 0 to 9) that is accepted sets the pending entry to (pending × 10 + digit) mod 1000. Only the three newest digits remain.
- R2: An accepted minus key (code 10) sets the pending sign flag, without changing the pending digits.
- R3: An accepted commit key (code 11) loads the converted entry into the target. The target direction bit is the pending sign, except that a zero target always has direction 0. The same key clears the pending digits and the sign flag.
- R4: The RPM entry is converted to speed units as (rpm × 5061 + 32768) >> 16. This is rounding to the nearest multiple of about 12.95 RPM.
- R5: A converted target above 63 units is loaded as 63. The limit is applied only when the target is loaded.
- R6: After an accepted key, ready is low for exactly HOLD_CYCLES clocks. A key presented while ready is low has no effect. Codes 12 to 15 have no effect and do not drop ready.
- R7: The working speed changes only on a clock with tick high. Each change is exactly one unit toward the target.
- R8: While speed differs from target, a step is taken on the N-th tick since the previous step or equality, where N = 19 − |speed| / 9 (integer division). N is 19 at zero and 12 at 63.
- R9: Going from one direction to the other passes through speed 0, and the direction bit is 0 whenever a magnitude is 0.
- R10: After reset, the entry, sign, target and speed are all zero, and ready is high.
- R11: While speed equals target, the speed holds and the tick count stays cleared, so a new target waits a full interval before its first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_valid | input | 1 | One-cycle strobe: a key code is present |
| key_code | input | 4 | 0–9 digit, 10 minus, 11 commit, others unused |
| tick | input | 1 | Update-cycle strobe that paces the ramp |
| pend_val | output | 10 | Pending RPM entry, 0 to 999 |
| pend_neg | output | 1 | Pending entry marked negative |
| ready | output | 1 | High when a new key will be accepted |
| target_mag | output | 6 | Target speed magnitude in units |
| target_neg | output | 1 | Target direction, 1 is reverse |
| speed_mag | output | 6 | Working speed magnitude in units |
| speed_neg | output | 1 | Working speed direction, 1 is reverse |

## Verification
Entries are keyed as short and overlong digit runs, so the three-digit window can be told apart from plain accumulation. They are also keyed as RPM values just either side of a half step, so nearest rounding can be told apart from truncation, and as an entry far above the limit, which exercises the clamp. The ramp is driven with continuous ticks from rest to a low target, up to a mid target, across zero to a reverse target, and then to the positive maximum. Every clock is compared against an independent step model, so the interval bands, the single-unit steps and the zero crossing are each pinned down. Keys sent during the hold time, unused codes, and a negative zero entry show that ignored input leaves the outputs unchanged.

// File: rtl/skr_pkg.sv
package skr_pkg;

    localparam int KEY_W = 4;

    localparam logic [KEY_W-1:0] KEY_DIGIT_MAX = 4'd9;
    localparam logic [KEY_W-1:0] KEY_MINUS     = 4'd10;
    localparam logic [KEY_W-1:0] KEY_COMMIT    = 4'd11;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_DIGIT  = 2'd1,
        ACT_MINUS  = 2'd2,
        ACT_COMMIT = 2'd3
    } key_act_e;

    function automatic key_act_e decode_key(input logic [KEY_W-1:0] code);
        key_act_e act;
        if (code <= KEY_DIGIT_MAX) begin
            act = ACT_DIGIT;
        end else if (code == KEY_MINUS) begin
            act = ACT_MINUS;
        end else if (code == KEY_COMMIT) begin
            act = ACT_COMMIT;
        end else begin
            act = ACT_NONE;
        end
        return act;
    endfunction

endpackage

// File: rtl/skr_entry.sv
module skr_entry
    import skr_pkg::*;
#(
    parameter int DIGITS      = 3,
    parameter int HOLD_CYCLES = 22500,
    localparam int MOD        = 10 ** DIGITS,
    localparam int VAL_W      = $clog2(MOD),
    localparam int WIDE_W     = VAL_W + 4,
    localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_code,
    output logic [VAL_W-1:0] pend_val,
    output logic             pend_neg,
    output logic             ready,
    output logic             commit,
    output logic [VAL_W-1:0] commit_val,
    output logic             commit_neg
);

    typedef struct packed {
        logic [VAL_W-1:0]  val;
        logic              neg;
        logic [HOLD_W-1:0] hold;
    } entry_t;

    entry_t           e_d, e_q;
    key_act_e         act;
    logic             accept;
    logic [WIDE_W-1:0] shifted;

    always_comb begin
        e_d     = e_q;
        act     = decode_key(key_code);
        accept  = key_valid && (e_q.hold == '0) && (act != ACT_NONE);
        shifted = WIDE_W'(e_q.val) * WIDE_W'(10) + WIDE_W'(key_code);
        commit  = 1'b0;

        if (e_q.hold != '0) begin
            e_d.hold = e_q.hold - HOLD_W'(1);
        end

        if (accept) begin
            e_d.hold = HOLD_W'(HOLD_CYCLES);
            unique case (act)
                ACT_DIGIT:  e_d.val = VAL_W'(shifted % WIDE_W'(MOD));
                ACT_MINUS:  e_d.neg = 1'b1;
                ACT_COMMIT: begin
                    commit  = 1'b1;
                    e_d.val = '0;
                    e_d.neg = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign pend_val   = e_q.val;
    assign pend_neg   = e_q.neg;
    assign ready      = (e_q.hold == '0);
    assign commit_val = e_q.val;
    assign commit_neg = e_q.neg;

endmodule

// File: rtl/skr_scale.sv
module skr_scale #(
    parameter int VAL_W         = 10,
    parameter int SPEED_W       = 6,
    parameter int SPEED_MAX     = 63,
    parameter int MUL           = 5061,
    parameter int SHIFT         = 16,
    parameter int ROUND_NEAREST = 1,
    localparam int MUL_W        = $clog2(MUL + 1),
    localparam int PROD_W       = VAL_W + MUL_W + 1
) (
    input  logic [VAL_W-1:0]   rpm,
    output logic [SPEED_W-1:0] units
);

    logic [PROD_W-1:0] bias;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    generate
        if (ROUND_NEAREST != 0) begin : g_nearest
            assign bias = PROD_W'(1) << (SHIFT - 1);
        end else begin : g_truncate
            assign bias = '0;
        end
    endgenerate

    always_comb begin
        prod  = PROD_W'(rpm) * PROD_W'(MUL);
        quot  = (prod + bias) >> SHIFT;
        units = (quot > PROD_W'(SPEED_MAX)) ? SPEED_W'(SPEED_MAX) : SPEED_W'(quot);
    end

endmodule

// File: rtl/skr_ramp.sv
module skr_ramp #(
    parameter int SPEED_W  = 6,
    parameter int INT_BASE = 19,
    parameter int INT_DIV  = 9,
    localparam int S_W     = SPEED_W + 1,
    localparam int CNT_W   = $clog2(INT_BASE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [SPEED_W-1:0] load_mag,
    input  logic               load_neg,
    output logic [SPEED_W-1:0] target_mag,
    output logic               target_neg,
    output logic [SPEED_W-1:0] speed_mag,
    output logic               speed_neg
);

    localparam logic signed [S_W-1:0] ONE = S_W'(1);

    typedef struct packed {
        logic [S_W-1:0]   tgt;
        logic [S_W-1:0]   spd;
        logic [CNT_W-1:0] cnt;
    } ramp_t;

    ramp_t                 r_d, r_q;
    logic signed [S_W-1:0] spd_q, tgt_q, load_s;
    logic [CNT_W-1:0]      interval;
    logic [CNT_W-1:0]      cnt_inc;

    always_comb begin
        spd_q  = $signed(r_q.spd);
        tgt_q  = $signed(r_q.tgt);
        load_s = $signed({1'b0, load_mag});
        if (load_neg) begin
            load_s = -load_s;
        end

        speed_mag  = spd_q[S_W-1] ? SPEED_W'(-spd_q) : SPEED_W'(spd_q);
        speed_neg  = spd_q[S_W-1];
        target_mag = tgt_q[S_W-1] ? SPEED_W'(-tgt_q) : SPEED_W'(tgt_q);
        target_neg = tgt_q[S_W-1];

        interval = CNT_W'(INT_BASE - int'(speed_mag) / INT_DIV);
        cnt_inc  = r_q.cnt + CNT_W'(1);

        r_d = r_q;
        if (spd_q == tgt_q) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= interval) begin
                r_d.cnt = '0;
                r_d.spd = (spd_q < tgt_q) ? (spd_q + ONE) : (spd_q - ONE);
            end else begin
                r_d.cnt = cnt_inc;
            end
        end

        if (load) begin
            r_d.tgt = load_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/speed_entry_ramp.sv
module speed_entry_ramp
    import skr_pkg::*;
#(
    parameter int DIGITS        = 3,
    parameter int HOLD_CYCLES   = 22500,
    parameter int SPEED_W       = 6,
    parameter int SPEED_MAX     = 63,
    parameter int INT_BASE      = 19,
    parameter int INT_DIV       = 9,
    parameter int SCALE_MUL     = 5061,
    parameter int SCALE_SHIFT   = 16,
    parameter int ROUND_NEAREST = 1,
    localparam int VAL_W        = $clog2(10 ** DIGITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_valid,
    input  logic [3:0]         key_code,
    input  logic               tick,
    output logic [VAL_W-1:0]   pend_val,
    output logic               pend_neg,
    output logic               ready,
    output logic [SPEED_W-1:0] target_mag,
    output logic               target_neg,
    output logic [SPEED_W-1:0] speed_mag,
    output logic               speed_neg
);

    logic               commit;
    logic [VAL_W-1:0]   commit_val;
    logic               commit_neg;
    logic [SPEED_W-1:0] commit_units;

    skr_entry #(
        .DIGITS      (DIGITS),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_valid  (key_valid),
        .key_code   (key_code),
        .pend_val   (pend_val),
        .pend_neg   (pend_neg),
        .ready      (ready),
        .commit     (commit),
        .commit_val (commit_val),
        .commit_neg (commit_neg)
    );

    skr_scale #(
        .VAL_W         (VAL_W),
        .SPEED_W       (SPEED_W),
        .SPEED_MAX     (SPEED_MAX),
        .MUL           (SCALE_MUL),
        .SHIFT         (SCALE_SHIFT),
        .ROUND_NEAREST (ROUND_NEAREST)
    ) u_scale (
        .rpm   (commit_val),
        .units (commit_units)
    );

    skr_ramp #(
        .SPEED_W  (SPEED_W),
        .INT_BASE (INT_BASE),
        .INT_DIV  (INT_DIV)
    ) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (commit),
        .load_mag   (commit_units),
        .load_neg   (commit_neg),
        .target_mag (target_mag),
        .target_neg (target_neg),
        .speed_mag  (speed_mag),
        .speed_neg  (speed_neg)
    );

endmodule

// File: rtl/speed_entry_ramp_chk.sv
module speed_entry_ramp_chk #(
    parameter int SPEED_W = 6,
    parameter int VAL_W   = 10,
    parameter int MIN_INT = 12,
    localparam int S_W    = SPEED_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               key_valid,
    input logic               ready,
    input logic [VAL_W-1:0]   pend_val,
    input logic               pend_neg,
    input logic [SPEED_W-1:0] target_mag,
    input logic               target_neg,
    input logic [SPEED_W-1:0] speed_mag,
    input logic               speed_neg
);

    localparam logic signed [S_W-1:0] ONE = S_W'(1);

    logic signed [S_W-1:0] spd_s, tgt_s;
    logic signed [S_W-1:0] spd_prev;
    logic [7:0]            gap_q;

    always_comb begin
        spd_s = $signed({1'b0, speed_mag});
        if (speed_neg) spd_s = -spd_s;
        tgt_s = $signed({1'b0, target_mag});
        if (target_neg) tgt_s = -tgt_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_prev <= '0;
            gap_q    <= '0;
        end else begin
            spd_prev <= spd_s;
            if (spd_s != spd_prev) begin
                gap_q <= '0;
            end else if (tick && gap_q != 8'hFF) begin
                gap_q <= gap_q + 8'd1;
            end
        end
    end

    // R7: any change is one unit toward the previous target
    a_r7_unit_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_s != $past(spd_s)) |->
            (($past(spd_s) < $past(tgt_s)) ? (spd_s == $past(spd_s) + ONE)
                                           : (spd_s == $past(spd_s) - ONE)));

    // R7: speed moves only on a tick
    a_r7_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_s != $past(spd_s)) |-> $past(tick));

    // R8: never faster than the shortest interval
    a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_s != $past(spd_s)) |-> (gap_q >= 8'(MIN_INT - 1)));

    // R9: no negative zero on either value
    a_r9_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((speed_mag == '0) |-> !speed_neg) and ((target_mag == '0) |-> !target_neg));

    // R6: keys during hold leave the entry alone
    a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !ready) |=> ($stable(pend_val) && $stable(pend_neg)));

    // R3: target changes only after an accepted key
    a_r3_target_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(target_mag) || !$stable(target_neg)) |-> $past(key_valid && ready));

endmodule

bind speed_entry_ramp speed_entry_ramp_chk #(
    .SPEED_W (SPEED_W),
    .VAL_W   (VAL_W),
    .MIN_INT (INT_BASE - SPEED_MAX / INT_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .key_valid  (key_valid),
    .ready      (ready),
    .pend_val   (pend_val),
    .pend_neg   (pend_neg),
    .target_mag (target_mag),
    .target_neg (target_neg),
    .speed_mag  (speed_mag),
    .speed_neg  (speed_neg)
);

// File: tb/speed_entry_ramp_tb.sv
module speed_entry_ramp_tb;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic       tick = 1'b0;
    logic [9:0] pend_val;
    logic       pend_neg;
    logic       ready;
    logic [5:0] target_mag;
    logic       target_neg;
    logic [5:0] speed_mag;
    logic       speed_neg;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    int m_pend = 0;
    int m_neg  = 0;
    int m_tgt  = 0;
    int m_spd  = 0;
    int m_cnt  = 0;

    always #5 clk = ~clk;

    speed_entry_ramp #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_valid  (key_valid),
        .key_code   (key_code),
        .tick       (tick),
        .pend_val   (pend_val),
        .pend_neg   (pend_neg),
        .ready      (ready),
        .target_mag (target_mag),
        .target_neg (target_neg),
        .speed_mag  (speed_mag),
        .speed_neg  (speed_neg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sval(input int mag, input logic neg);
        return neg ? -mag : mag;
    endfunction

    function automatic int units_of(input int rpm);
        int u;
        u = (rpm * 5061 + 32768) >>> 16;
        return (u > 63) ? 63 : u;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic press(input logic [3:0] code);
        @(negedge clk);
        while (ready !== 1'b1) @(negedge clk);
        key_valid = 1'b1;
        key_code  = code;
        @(negedge clk);
        key_valid = 1'b0;
        if (code <= 4'd9) begin
            m_pend = (m_pend * 10 + int'(code)) % 1000;
        end else if (code == 4'd10) begin
            m_neg = 1;
        end else if (code == 4'd11) begin
            m_tgt  = m_neg ? -units_of(m_pend) : units_of(m_pend);
            m_pend = 0;
            m_neg  = 0;
        end
    endtask

    task automatic model_tick();
        if (m_spd == m_tgt) begin
            m_cnt = 0;
        end else if (m_cnt + 1 >= 19 - iabs(m_spd) / 9) begin
            m_spd = m_spd + ((m_spd < m_tgt) ? 1 : -1);
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic cmp_speed();
        chk("R7", "speed", sval(int'(speed_mag), speed_neg), m_spd);
        if (speed_mag == 6'd0) chk("R9", "zero direction", int'(speed_neg), 0);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_speed();
            tick = 1'b1;
            model_tick();
        end
        @(negedge clk);
        tick = 1'b0;
        cmp_speed();
    endtask

    task automatic t_reset();
        chk("R10", "pend_val", int'(pend_val), 0);
        chk("R10", "pend_neg", int'(pend_neg), 0);
        chk("R10", "ready", int'(ready), 1);
        chk("R10", "target", sval(int'(target_mag), target_neg), 0);
        chk("R10", "speed", sval(int'(speed_mag), speed_neg), 0);
    endtask

    task automatic t_digits();
        press(4'd1); press(4'd2); press(4'd3);
        chk("R1", "three digits", int'(pend_val), 123);
        press(4'd4);
        chk("R1", "oldest dropped", int'(pend_val), 234);
        press(4'd5); press(4'd0);
        chk("R1", "window slides", int'(pend_val), 450);
    endtask

    task automatic t_ready();
        int low;
        press(4'd7);
        chk("R1", "entry 507", int'(pend_val), 507);
        low = 0;
        while (ready !== 1'b1) begin
            low++;
            @(negedge clk);
        end
        chk("R6", "hold length", low, HOLD);
        press(4'd8);
        key_valid = 1'b1;
        key_code  = 4'd9;
        @(negedge clk);
        key_valid = 1'b0;
        while (ready !== 1'b1) @(negedge clk);
        chk("R6", "key during hold ignored", int'(pend_val), 78);
        key_valid = 1'b1;
        key_code  = 4'd13;
        @(negedge clk);
        key_valid = 1'b0;
        chk("R6", "unused code keeps ready", int'(ready), 1);
        chk("R6", "unused code keeps entry", int'(pend_val), 78);
        chk("R6", "unused code keeps sign", int'(pend_neg), 0);
    endtask

    task automatic t_first_ramp();
        press(4'd11);
        chk("R3", "target from 78 rpm", sval(int'(target_mag), target_neg), 6);
        chk("R3", "entry cleared", int'(pend_val), 0);
        run_ticks(18);
        chk("R8", "no step before 19 ticks", int'(speed_mag), 0);
        run_ticks(1);
        chk("R8", "step on 19th tick", int'(speed_mag), 1);
        run_ticks(120);
        chk("R11", "holds at target", sval(int'(speed_mag), speed_neg), 6);
    endtask

    task automatic t_rounding();
        press(4'd6); press(4'd11);
        chk("R4", "6 rpm rounds to 0", int'(target_mag), 0);
        press(4'd7); press(4'd11);
        chk("R4", "7 rpm rounds to 1", int'(target_mag), 1);
        press(4'd5); press(4'd0); press(4'd0); press(4'd11);
        chk("R4", "500 rpm", sval(int'(target_mag), target_neg), 39);
        run_ticks(700);
        chk("R8", "reached 39", sval(int'(speed_mag), speed_neg), 39);
    endtask

    task automatic t_reverse();
        press(4'd10);
        chk("R2", "minus sets sign", int'(pend_neg), 1);
        chk("R2", "minus keeps digits", int'(pend_val), 0);
        press(4'd1); press(4'd0); press(4'd0);
        press(4'd11);
        chk("R3", "negative target", sval(int'(target_mag), target_neg), -8);
        chk("R3", "sign cleared", int'(pend_neg), 0);
        run_ticks(900);
        chk("R9", "reached reverse speed", sval(int'(speed_mag), speed_neg), -8);
        press(4'd10); press(4'd11);
        chk("R3", "negative zero magnitude", int'(target_mag), 0);
        chk("R3", "negative zero direction", int'(target_neg), 0);
    endtask

    task automatic t_clamp();
        press(4'd9); press(4'd0); press(4'd0); press(4'd11);
        chk("R5", "900 rpm clamped", sval(int'(target_mag), target_neg), 63);
        run_ticks(1400);
        chk("R5", "reached limit", sval(int'(speed_mag), speed_neg), 63);
        run_ticks(30);
        chk("R11", "still at limit", int'(speed_mag), 63);
        press(4'd8); press(4'd0); press(4'd3); press(4'd11);
        chk("R4", "803 rpm", int'(target_mag), 62);
        run_ticks(11);
        chk("R8", "no step before 12 ticks", int'(speed_mag), 63);
        run_ticks(1);
        chk("R8", "step on 12th tick", int'(speed_mag), 62);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_digits();
        t_ready();
        t_first_ramp();
        t_rounding();
        t_reverse();
        t_clamp();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule